// File: doc/BRIEF.md
# Poison-Tagged General Register File

This block is a small general register file for a core that issues loads speculatively. Each register holds a data word and one poison tag. A set tag means the register holds a deferred fault token and no valid data. The block takes one simplified micro-operation per cycle. It writes back results, sets and spreads the tag, and reports one of three events: a consumption fault, a redirect to recovery code, or a predicate.

A speculative load that met a deferrable fault writes its destination with the tag set, and does not trap. A speculative ALU operation passes the tag on from any tagged source to its destination, so a whole dependent chain stays poisoned. A check operation turns a set tag into a redirect to the recovery target it carries. A non-speculative ALU operation, or a store, that reads a tagged register raises a consumption fault. A test operation copies the tag into a predicate. All results appear on registered outputs one cycle after the operation is accepted.

Top module: `poison_regfile`

## Requirements
- R1: After reset, every register reads value zero with its tag clear.
- R2: A load (op code 1) writes `op_data` to the destination register. The tag is set when `op_load_fault` is 1 and cleared otherwise, and this replaces whatever the register held before. A load never faults.
- R3: An add (op code 2) with `op_spec` = 1 writes the sum of its sources to the destination register. The destination tag is the OR of the two source tags. It never faults.
- R4: A check (op code 3) on a register whose tag is set gives `redirect_o` = 1 with `redirect_pc_o` = `op_target`. A check on a register whose tag is clear gives no redirect and no fault.
- R5: An add with `op_spec` = 0 that has a tagged source writes nothing and gives `fault_o` = 1 with `fault_reg_o` naming the tagged source. With both sources clean, it writes the sum with the tag clear.
- R6: A store (op code 5) reads `op_src_a` as the address and `op_src_b` as the data. If either source is tagged, it gives a fault naming that source and no store. Otherwise it gives `st_valid_o` = 1 with both values.
- R7: A test (op code 4) gives `pred_valid_o` = 1 with `pred_o` equal to the tag of `op_src_a`, and never faults.
- R8: Register 0 always reads zero with its tag clear, and any write to it is ignored.
- R9: When both sources of a faulting add or store are tagged, `fault_reg_o` is the lower register index.
- R10: Each event output is a single-cycle pulse in the cycle after its operation is accepted. At most one of fault, redirect, predicate and store is raised in a cycle. Op code 0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 3 | 0 nop, 1 load, 2 add, 3 check, 4 test, 5 store |
| op_spec | input | 1 | Add is speculative |
| op_dst | input | 4 | Destination register |
| op_src_a | input | 4 | First source (checked, tested, store address) |
| op_src_b | input | 4 | Second source (store data) |
| op_data | input | 32 | Load return data |
| op_load_fault | input | 1 | Load met a deferred fault |
| op_target | input | 16 | Recovery target of a check |
| fault_o | output | 1 | Consumption fault pulse |
| fault_reg_o | output | 4 | Register that caused the fault |
| redirect_o | output | 1 | Redirect to recovery pulse |
| redirect_pc_o | output | 16 | Recovery target |
| pred_valid_o | output | 1 | Test result pulse |
| pred_o | output | 1 | Tag value returned by a test |
| st_valid_o | output | 1 | Store issued pulse |
| st_addr_o | output | 32 | Store address value |
| st_data_o | output | 32 | Store data value |

## Verification
The hardest case is a non-speculative add or a store whose two sources are both tagged, with the higher index in the first operand slot. The bench first plants tags through faulting loads and a speculative add chain. It then issues the faulting operation with the operands in both orders. A later test and store on the destination show that the faulting add left the register unwritten. A long random sequence follows, with a small register window and a high fault rate on loads, so that tags spread and meet often.

// File: rtl/ptag_pkg.sv
package ptag_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_ADD   = 3'd2,
    OP_CHECK = 3'd3,
    OP_TEST  = 3'd4,
    OP_STORE = 3'd5
  } op_e;
endpackage

// File: rtl/ptag_rf_store.sv
module ptag_rf_store #(
  parameter int NREGS = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_val,
  input  logic          wr_tag,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_a_val,
  output logic          rd_a_tag,
  output logic [DW-1:0] rd_b_val,
  output logic          rd_b_tag
);
  logic [DW-1:0] val_arr [NREGS];
  logic          tag_arr [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    if (r == 0) begin : g_zero
      // Hard-wired zero entry; writes are dropped.
      assign val_arr[r] = '0;
      assign tag_arr[r] = 1'b0;
    end else begin : g_live
      logic          en;
      logic [DW-1:0] val_q;
      logic          tag_q;
      assign en = wr_en && (wr_idx == IW'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= '0;
          tag_q <= 1'b0;
        end else if (en) begin
          val_q <= wr_val;
          tag_q <= wr_tag;
        end
      end
      assign val_arr[r] = val_q;
      assign tag_arr[r] = tag_q;
    end
  end

  assign rd_a_val = val_arr[rd_a_idx];
  assign rd_a_tag = tag_arr[rd_a_idx];
  assign rd_b_val = val_arr[rd_b_idx];
  assign rd_b_tag = tag_arr[rd_b_idx];
endmodule

// File: rtl/ptag_exec.sv
module ptag_exec
  import ptag_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int DW    = 32,
  parameter int PCW   = 16,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic           op_valid,
  input  logic [2:0]     op_code,
  input  logic           op_spec,
  input  logic [IW-1:0]  op_dst,
  input  logic [IW-1:0]  op_src_a,
  input  logic [IW-1:0]  op_src_b,
  input  logic [DW-1:0]  op_data,
  input  logic           op_load_fault,
  input  logic [PCW-1:0] op_target,
  input  logic [DW-1:0]  a_val,
  input  logic           a_tag,
  input  logic [DW-1:0]  b_val,
  input  logic           b_tag,
  output logic           wr_en,
  output logic [IW-1:0]  wr_idx,
  output logic [DW-1:0]  wr_val,
  output logic           wr_tag,
  output logic           nx_fault,
  output logic [IW-1:0]  nx_fault_reg,
  output logic           nx_redir,
  output logic [PCW-1:0] nx_redir_pc,
  output logic           nx_pred_v,
  output logic           nx_pred,
  output logic           nx_st_v,
  output logic [DW-1:0]  nx_st_addr,
  output logic [DW-1:0]  nx_st_data
);
  op_e          op;
  logic         any_tag;
  logic [IW-1:0] blame;

  assign op      = op_e'(op_code);
  assign any_tag = a_tag | b_tag;

  // Blame the lower index when both sources are poisoned.
  always_comb begin
    if (a_tag && b_tag) blame = (op_src_a < op_src_b) ? op_src_a : op_src_b;
    else if (a_tag)     blame = op_src_a;
    else                blame = op_src_b;
  end

  always_comb begin
    wr_en        = 1'b0;
    wr_idx       = op_dst;
    wr_val       = a_val + b_val;
    wr_tag       = 1'b0;
    nx_fault     = 1'b0;
    nx_fault_reg = blame;
    nx_redir     = 1'b0;
    nx_redir_pc  = op_target;
    nx_pred_v    = 1'b0;
    nx_pred      = a_tag;
    nx_st_v      = 1'b0;
    nx_st_addr   = a_val;
    nx_st_data   = b_val;
    if (op_valid) begin
      unique case (op)
        OP_LOAD: begin
          wr_en  = 1'b1;
          wr_val = op_data;
          wr_tag = op_load_fault;
        end
        OP_ADD: begin
          if (op_spec) begin
            wr_en  = 1'b1;
            wr_tag = any_tag;
          end else if (any_tag) begin
            nx_fault = 1'b1;
          end else begin
            wr_en = 1'b1;
          end
        end
        OP_CHECK: nx_redir  = a_tag;
        OP_TEST:  nx_pred_v = 1'b1;
        OP_STORE: begin
          if (any_tag) nx_fault = 1'b1;
          else         nx_st_v  = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ptag_out_stage.sv
module ptag_out_stage #(
  parameter int IW  = 4,
  parameter int DW  = 32,
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           nx_fault,
  input  logic [IW-1:0]  nx_fault_reg,
  input  logic           nx_redir,
  input  logic [PCW-1:0] nx_redir_pc,
  input  logic           nx_pred_v,
  input  logic           nx_pred,
  input  logic           nx_st_v,
  input  logic [DW-1:0]  nx_st_addr,
  input  logic [DW-1:0]  nx_st_data,
  output logic           fault_o,
  output logic [IW-1:0]  fault_reg_o,
  output logic           redirect_o,
  output logic [PCW-1:0] redirect_pc_o,
  output logic           pred_valid_o,
  output logic           pred_o,
  output logic           st_valid_o,
  output logic [DW-1:0]  st_addr_o,
  output logic [DW-1:0]  st_data_o
);
  // Pulses register every cycle; payloads load only with their pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_o      <= 1'b0;
      redirect_o   <= 1'b0;
      pred_valid_o <= 1'b0;
      st_valid_o   <= 1'b0;
    end else begin
      fault_o      <= nx_fault;
      redirect_o   <= nx_redir;
      pred_valid_o <= nx_pred_v;
      st_valid_o   <= nx_st_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault_reg_o <= '0;
    else if (nx_fault) fault_reg_o <= nx_fault_reg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        redirect_pc_o <= '0;
    else if (nx_redir) redirect_pc_o <= nx_redir_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pred_o <= 1'b0;
    else if (nx_pred_v) pred_o <= nx_pred;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_addr_o <= '0;
      st_data_o <= '0;
    end else if (nx_st_v) begin
      st_addr_o <= nx_st_addr;
      st_data_o <= nx_st_data;
    end
  end
endmodule

// File: rtl/poison_regfile.sv
module poison_regfile #(
  parameter int NREGS = 16,
  parameter int DW    = 32,
  parameter int PCW   = 16,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [2:0]     op_code,
  input  logic           op_spec,
  input  logic [IW-1:0]  op_dst,
  input  logic [IW-1:0]  op_src_a,
  input  logic [IW-1:0]  op_src_b,
  input  logic [DW-1:0]  op_data,
  input  logic           op_load_fault,
  input  logic [PCW-1:0] op_target,
  output logic           fault_o,
  output logic [IW-1:0]  fault_reg_o,
  output logic           redirect_o,
  output logic [PCW-1:0] redirect_pc_o,
  output logic           pred_valid_o,
  output logic           pred_o,
  output logic           st_valid_o,
  output logic [DW-1:0]  st_addr_o,
  output logic [DW-1:0]  st_data_o
);
  logic           wr_en, wr_tag;
  logic [IW-1:0]  wr_idx;
  logic [DW-1:0]  wr_val;
  logic [DW-1:0]  a_val, b_val;
  logic           a_tag, b_tag;
  logic           nx_fault, nx_redir, nx_pred_v, nx_pred, nx_st_v;
  logic [IW-1:0]  nx_fault_reg;
  logic [PCW-1:0] nx_redir_pc;
  logic [DW-1:0]  nx_st_addr, nx_st_data;

  ptag_rf_store #(.NREGS(NREGS), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val), .wr_tag(wr_tag),
    .rd_a_idx(op_src_a), .rd_b_idx(op_src_b),
    .rd_a_val(a_val), .rd_a_tag(a_tag), .rd_b_val(b_val), .rd_b_tag(b_tag)
  );

  ptag_exec #(.NREGS(NREGS), .DW(DW), .PCW(PCW)) u_exec (
    .op_valid(op_valid), .op_code(op_code), .op_spec(op_spec),
    .op_dst(op_dst), .op_src_a(op_src_a), .op_src_b(op_src_b),
    .op_data(op_data), .op_load_fault(op_load_fault), .op_target(op_target),
    .a_val(a_val), .a_tag(a_tag), .b_val(b_val), .b_tag(b_tag),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val), .wr_tag(wr_tag),
    .nx_fault(nx_fault), .nx_fault_reg(nx_fault_reg),
    .nx_redir(nx_redir), .nx_redir_pc(nx_redir_pc),
    .nx_pred_v(nx_pred_v), .nx_pred(nx_pred),
    .nx_st_v(nx_st_v), .nx_st_addr(nx_st_addr), .nx_st_data(nx_st_data)
  );

  ptag_out_stage #(.IW(IW), .DW(DW), .PCW(PCW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .nx_fault(nx_fault), .nx_fault_reg(nx_fault_reg),
    .nx_redir(nx_redir), .nx_redir_pc(nx_redir_pc),
    .nx_pred_v(nx_pred_v), .nx_pred(nx_pred),
    .nx_st_v(nx_st_v), .nx_st_addr(nx_st_addr), .nx_st_data(nx_st_data),
    .fault_o(fault_o), .fault_reg_o(fault_reg_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .pred_valid_o(pred_valid_o), .pred_o(pred_o),
    .st_valid_o(st_valid_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );
endmodule

// File: rtl/ptag_checker.sv
module ptag_checker
  import ptag_pkg::*;
#(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic          op_spec,
  input logic          fault_o,
  input logic [IW-1:0] fault_reg_o,
  input logic          redirect_o,
  input logic          pred_valid_o,
  input logic          st_valid_o
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R10: event outputs never overlap
  assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fault_o, redirect_o, pred_valid_o, st_valid_o}) <= 1);

  // R8: register 0 can never be the poisoned culprit
  assert_zero_never_blamed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (fault_reg_o != '0));

  // R4: a redirect follows only a check
  assert_redirect_from_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && redirect_o) |-> $past(op_valid && op_code == OP_CHECK));

  // R7: a test always answers and never faults
  assert_test_answers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(op_valid && op_code == OP_TEST)) |-> (pred_valid_o && !fault_o));

  // R5 / R6: faults come only from non-speculative adds and stores
  assert_fault_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && fault_o) |->
      $past(op_valid && ((op_code == OP_ADD && !op_spec) || op_code == OP_STORE)));

  // R2 / R3: loads and speculative adds never fault
  assert_spec_never_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(op_valid && (op_code == OP_LOAD || (op_code == OP_ADD && op_spec))))
      |-> !fault_o);
endmodule

bind poison_regfile ptag_checker #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .op_spec(op_spec), .fault_o(fault_o), .fault_reg_o(fault_reg_o),
  .redirect_o(redirect_o), .pred_valid_o(pred_valid_o), .st_valid_o(st_valid_o)
);

// File: tb/poison_regfile_tb.sv
`timescale 1ns/1ps
module poison_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_spec, op_load_fault;
  logic [2:0]  op_code;
  logic [3:0]  op_dst, op_src_a, op_src_b;
  logic [31:0] op_data;
  logic [15:0] op_target;
  logic        fault_o, redirect_o, pred_valid_o, pred_o, st_valid_o;
  logic [3:0]  fault_reg_o;
  logic [15:0] redirect_pc_o;
  logic [31:0] st_addr_o, st_data_o;

  always #2.5 clk = ~clk;

  poison_regfile u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // Behavioural reference state
  logic [31:0] mval [16];
  bit          mtag [16];

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Issue one operation, predict from the model, compare one cycle later.
  task automatic do_op(string req, int code, bit spec, int dst, int sa, int sb,
                       logic [31:0] data, bit lf, logic [15:0] tgt);
    bit e_f = 0, e_r = 0, e_p = 0, e_s = 0, e_pv = 0;
    int e_fr = 0;
    logic [31:0] av, bv, ea = 0, ed = 0;
    bit at, bt;
    av = (sa == 0) ? 32'h0 : mval[sa]; at = (sa == 0) ? 1'b0 : mtag[sa];
    bv = (sb == 0) ? 32'h0 : mval[sb]; bt = (sb == 0) ? 1'b0 : mtag[sb];
    case (code)
      1: if (dst != 0) begin mval[dst] = data; mtag[dst] = lf; end
      2: if (spec || !(at || bt)) begin
           if (dst != 0) begin mval[dst] = av + bv; mtag[dst] = spec && (at || bt); end
         end else begin
           e_f = 1;
           e_fr = (at && bt) ? ((sa < sb) ? sa : sb) : (at ? sa : sb);
         end
      3: e_r = at;
      4: begin e_p = 1; e_pv = at; end
      5: if (at || bt) begin
           e_f = 1;
           e_fr = (at && bt) ? ((sa < sb) ? sa : sb) : (at ? sa : sb);
         end else begin e_s = 1; ea = av; ed = bv; end
      default: ;
    endcase
    op_valid = 1; op_code = 3'(code); op_spec = spec; op_dst = 4'(dst);
    op_src_a = 4'(sa); op_src_b = 4'(sb); op_data = data;
    op_load_fault = lf; op_target = tgt;
    @(posedge clk); #1;
    op_valid = 0;
    chk(req, "fault", fault_o, e_f);
    chk(req, "redirect", redirect_o, e_r);
    chk(req, "pred_valid", pred_valid_o, e_p);
    chk(req, "st_valid", st_valid_o, e_s);
    if (e_f) chk(req, "fault_reg", fault_reg_o, e_fr);
    if (e_r) chk(req, "redirect_pc", redirect_pc_o, tgt);
    if (e_p) chk(req, "pred", pred_o, e_pv);
    if (e_s) begin
      chk(req, "st_addr", st_addr_o, ea);
      chk(req, "st_data", st_data_o, ed);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mval[i] = 0; mtag[i] = 0; end
    op_valid = 0; op_code = 0; op_spec = 0; op_dst = 0; op_src_a = 0;
    op_src_b = 0; op_data = 0; op_load_fault = 0; op_target = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state of outputs and registers
    chk("R1", "fault after reset", fault_o, 0);
    chk("R1", "st_valid after reset", st_valid_o, 0);
    for (int r = 1; r < 16; r++) do_op("R1", 4, 0, 0, r, 0, 0, 0, 0);
    do_op("R1", 5, 0, 0, 3, 9, 0, 0, 0);
    // R2: clean loads
    do_op("R2", 1, 0, 1, 0, 0, 32'h10, 0, 0);
    do_op("R2", 1, 0, 2, 0, 0, 32'h20, 0, 0);
    do_op("R2", 5, 0, 0, 1, 2, 0, 0, 0);
    // R2: faulting load sets tag; R7 sees it
    do_op("R2", 1, 0, 3, 0, 0, 32'hdead, 1, 0);
    do_op("R7", 4, 0, 0, 3, 0, 0, 0, 0);
    // R3: propagation and clean speculative add
    do_op("R3", 2, 1, 4, 1, 3, 0, 0, 0);
    do_op("R3", 4, 0, 0, 4, 0, 0, 0, 0);
    do_op("R3", 2, 1, 5, 1, 2, 0, 0, 0);
    do_op("R3", 5, 0, 0, 5, 1, 0, 0, 0);
    // R4: check on tagged and clean registers
    do_op("R4", 3, 0, 0, 4, 0, 0, 0, 16'h0123);
    do_op("R4", 3, 0, 0, 5, 0, 0, 0, 16'h0456);
    // R5: non-spec add consuming a tag, no write
    do_op("R5", 2, 0, 6, 1, 4, 0, 0, 0);
    do_op("R5", 4, 0, 0, 6, 0, 0, 0, 0);
    do_op("R5", 5, 0, 0, 6, 1, 0, 0, 0);
    do_op("R5", 2, 0, 6, 1, 2, 0, 0, 0);
    do_op("R5", 5, 0, 0, 6, 6, 0, 0, 0);
    // R6: store with tagged data / address
    do_op("R6", 5, 0, 0, 1, 3, 0, 0, 0);
    do_op("R6", 5, 0, 0, 4, 1, 0, 0, 0);
    // R9: both tagged, both operand orders
    do_op("R9", 2, 0, 7, 4, 3, 0, 0, 0);
    do_op("R9", 2, 0, 7, 3, 4, 0, 0, 0);
    do_op("R9", 5, 0, 0, 4, 3, 0, 0, 0);
    // R8: register 0 ignores writes
    do_op("R8", 1, 0, 0, 0, 0, 32'h55, 1, 0);
    do_op("R8", 4, 0, 0, 0, 0, 0, 0, 0);
    do_op("R8", 2, 1, 0, 4, 1, 0, 0, 0);
    do_op("R8", 5, 0, 0, 0, 0, 0, 0, 0);
    // R2: clean load overwrites a poisoned register
    do_op("R2", 1, 0, 3, 0, 0, 32'h77, 0, 0);
    do_op("R2", 4, 0, 0, 3, 0, 0, 0, 0);
    // R10: no-op raises nothing; back-to-back events each last one cycle
    do_op("R10", 0, 0, 2, 1, 1, 32'h1, 1, 0);
    do_op("R10", 3, 0, 0, 4, 0, 0, 0, 16'h00aa);
    do_op("R10", 3, 0, 0, 4, 0, 0, 0, 16'h00bb);
    do_op("R10", 0, 0, 0, 0, 0, 0, 0, 0);
    // Random mix over a small register window
    for (int n = 0; n < 3000; n++) begin
      int c = $urandom_range(0, 5);
      do_op("R10", c, 1'($urandom_range(0, 1)), $urandom_range(0, 7),
            $urandom_range(0, 7), $urandom_range(0, 7), $urandom,
            ($urandom_range(0, 2) == 0), 16'($urandom));
    end
    finish_run();
  end
endmodule